// File: doc/BRIEF.md
# Debug Scan-Chain Select TAP

This block is the JTAG test access port in front of a processor's debug logic. It runs the standard sixteen-state TAP controller on TCK and TMS, holds a 5-bit instruction register, and keeps a 5-bit chain number. That number decides which of several downstream debug data chains is connected between TDI and TDO. Each chain module receives its own capture, shift and update strobes. The chain modules also see the current instruction, so they can tell a read (INTEST) from a write (EXTEST).

A host picks a chain in three steps. It loads the SCAN_N instruction. It shifts a chain number into the select register. It then loads EXTEST or INTEST to reach that chain. A dedicated ITRSEL instruction connects chain 4 directly and leaves the stored chain number alone. When the select register is captured it returns a fixed pattern, and the host uses that pattern to confirm the link works. The IDCODE and BYPASS registers are part of this block. The contents of the individual chains are not.

Top module: `dbg_tap_sel`

## Requirements
- R1: An active-low trst_n, or one rising TCK edge spent in Test-Logic-Reset, sets the instruction to IDCODE (0x1E) and the chain number to 0. While trst_n is low, tdo_en is low.
- R2: Under IDCODE (0x1E), the data register is 32 bits and holds the IDCODE parameter. It shifts out least significant bit first.
- R3: The defined codes are EXTEST 0x00, SCAN_N 0x02, RESTART 0x04, HALT 0x08, INTEST 0x0C, ITRSEL 0x1D, IDCODE 0x1E and BYPASS 0x1F. Any other code updated into the instruction register becomes BYPASS (0x1F). Under BYPASS, RESTART and HALT the data path is a 1-bit register that captures 0.
- R4: Capture-IR loads 5'b00001 into the instruction shifter, so the first five bits shifted out are 1,0,0,0,0.
- R5: Under SCAN_N (0x02), the data register is the 5-bit select register. Its capture value is 0x10.
- R6: A chain number shifted under SCAN_N reaches chain_sel only when the TAP passes Update-DR. chain_sel does not change while the TAP waits in Pause-DR.
- R7: Under EXTEST, INTEST or ITRSEL, TDO follows chain_tdo[chain_sel]. Only that chain's capture, shift and update strobes are asserted, in Capture-DR, Shift-DR and Update-DR.
- R8: ITRSEL (0x1D) makes chain_sel read 4 and routes chain 4. The stored chain number is not changed, so a later EXTEST returns to the previous chain.
- R9: The TAP may go from Pause-IR or Pause-DR through Exit2, Update, Select and Capture back into Shift without visiting Run-Test/Idle. The update on that path takes effect.
- R10: tdo and tdo_en change on the falling edge of TCK. tdo_en is high only after a falling edge in Shift-IR or Shift-DR.
- R11: Five TCK cycles with TMS high reach Test-Logic-Reset from any state, including Shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on the falling TCK edge |
| tdo_en | output | 1 | High while tdo carries shift data |
| instr | output | 5 | Current decoded instruction |
| chain_sel | output | 5 | Chain currently routed (4 under ITRSEL) |
| chain_tdo | input | NCHAINS | Serial outputs of the downstream chains |
| chain_capture | output | NCHAINS | Per-chain capture strobe |
| chain_shift | output | NCHAINS | Per-chain shift strobe |
| chain_update | output | NCHAINS | Per-chain update strobe |

## Verification
Each chain drives a constant bit: chains 1 and 4 drive 1 and the others drive 0. Routing to chain 0, chain 1 or chain 4 can therefore be read directly off the shifted TDO stream, and the update strobe that fires shows which chain was addressed. A non-symmetric byte shifted through the bypass paths shows both the one-bit delay and the captured zero, which tells a 1-bit register apart from a wired-through path. The pause-and-resume sequences check whether an update taken without Run-Test/Idle still takes effect, and whether a chain number parked in Pause-DR stays invisible until that update.

// File: rtl/dbg_tap_sel.sv
module dbg_tap_sel #(
  parameter int          NCHAINS   = 8,
  parameter logic [31:0] IDCODE_VAL = 32'h1234_5679
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_en,
  output logic [4:0]         instr,
  output logic [4:0]         chain_sel,
  input  logic [NCHAINS-1:0] chain_tdo,
  output logic [NCHAINS-1:0] chain_capture,
  output logic [NCHAINS-1:0] chain_shift,
  output logic [NCHAINS-1:0] chain_update
);
  localparam int CW = (NCHAINS > 1) ? $clog2(NCHAINS) : 1;

  localparam logic [4:0] I_EXTEST  = 5'h00;
  localparam logic [4:0] I_SCANN   = 5'h02;
  localparam logic [4:0] I_RESTART = 5'h04;
  localparam logic [4:0] I_HALT    = 5'h08;
  localparam logic [4:0] I_INTEST  = 5'h0C;
  localparam logic [4:0] I_ITRSEL  = 5'h1D;
  localparam logic [4:0] I_IDCODE  = 5'h1E;
  localparam logic [4:0] I_BYPASS  = 5'h1F;

  typedef enum logic [3:0] {
    S_TLR, S_IDLE, S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PDR, S_EX2DR, S_UPDR,
    S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PIR, S_EX2IR, S_UPIR
  } tap_st_t;

  tap_st_t st, st_nx;
  logic [4:0]  ir, ir_sh, sel_reg, sel_sh;
  logic [31:0] id_sh;
  logic        byp, dr_bit, chain_mode, chain_ok, legal;
  logic [4:0]  active;

  always_comb begin
    unique case (st)
      S_TLR:   st_nx = tms ? S_TLR   : S_IDLE;
      S_IDLE:  st_nx = tms ? S_SELDR : S_IDLE;
      S_SELDR: st_nx = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: st_nx = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  st_nx = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: st_nx = tms ? S_UPDR  : S_PDR;
      S_PDR:   st_nx = tms ? S_EX2DR : S_PDR;
      S_EX2DR: st_nx = tms ? S_UPDR  : S_SHDR;
      S_UPDR:  st_nx = tms ? S_SELDR : S_IDLE;
      S_SELIR: st_nx = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: st_nx = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  st_nx = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: st_nx = tms ? S_UPIR  : S_PIR;
      S_PIR:   st_nx = tms ? S_EX2IR : S_PIR;
      S_EX2IR: st_nx = tms ? S_UPIR  : S_SHIR;
      default: st_nx = tms ? S_SELDR : S_IDLE;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) st <= S_TLR;
    else         st <= st_nx;

  assign legal = ir_sh inside {I_EXTEST, I_SCANN, I_RESTART, I_HALT,
                               I_INTEST, I_ITRSEL, I_IDCODE, I_BYPASS};

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir      <= I_IDCODE;
      sel_reg <= 5'd0;
      ir_sh   <= 5'd0;
    end else begin
      if (st == S_TLR) begin
        ir      <= I_IDCODE;
        sel_reg <= 5'd0;
      end
      if (st == S_CAPIR) ir_sh <= 5'b00001;
      if (st == S_SHIR)  ir_sh <= {tdi, ir_sh[4:1]};
      if (st == S_UPIR)  ir    <= legal ? ir_sh : I_BYPASS;
      if (st == S_UPDR && ir == I_SCANN) sel_reg <= sel_sh;
    end
  end

  always_ff @(posedge tck) begin
    if (st == S_CAPDR) begin
      id_sh  <= IDCODE_VAL;
      sel_sh <= 5'h10;
      byp    <= 1'b0;
    end else if (st == S_SHDR) begin
      id_sh  <= {tdi, id_sh[31:1]};
      sel_sh <= {tdi, sel_sh[4:1]};
      byp    <= tdi;
    end
  end

  assign chain_mode = (ir == I_EXTEST) || (ir == I_INTEST) || (ir == I_ITRSEL);
  assign active     = (ir == I_ITRSEL) ? 5'd4 : sel_reg;
  assign chain_ok   = 32'(active) < NCHAINS;
  assign chain_sel  = active;
  assign instr      = ir;

  always_comb begin
    unique case (ir)
      I_IDCODE: dr_bit = id_sh[0];
      I_SCANN:  dr_bit = sel_sh[0];
      default:  dr_bit = (chain_mode && chain_ok) ? chain_tdo[active[CW-1:0]] : byp;
    endcase
  end

  for (genvar g = 0; g < NCHAINS; g++) begin : g_strobe
    logic hit;
    assign hit              = chain_mode && (active == 5'(g));
    assign chain_capture[g] = hit && (st == S_CAPDR);
    assign chain_shift[g]   = hit && (st == S_SHDR);
    assign chain_update[g]  = hit && (st == S_UPDR);
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo    <= (st == S_SHIR) ? ir_sh[0] : (st == S_SHDR) ? dr_bit : 1'b0;
      tdo_en <= (st == S_SHIR) || (st == S_SHDR);
    end
  end

  // R1
  tlr_init_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_TLR) |=> (instr == I_IDCODE && chain_sel == 5'd0));

  // R6
  sel_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (!(st == S_UPDR && ir == I_SCANN) && st != S_TLR) |=> $stable(sel_reg));

  // R7
  one_update_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(chain_update) && $onehot0(chain_shift) && $onehot0(chain_capture));

  // R10
  tdo_en_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (st == S_SHDR || st == S_SHIR));

  // R3
  ir_legal_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st == S_UPIR && !legal) |=> (instr == I_BYPASS));
endmodule

// File: tb/tb_dbg_tap_sel.sv
`timescale 1ns/1ps
module tb_dbg_tap_sel;
  localparam int          NCH = 8;
  localparam logic [31:0] IDV = 32'h1234_5679;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdo_en;
  logic [4:0] instr, chain_sel;
  logic [NCH-1:0] chain_tdo, chain_capture, chain_shift, chain_update;
  logic [NCH-1:0] upd_seen;
  int checks = 0, fails = 0;
  logic last_tdo;

  always #4 tck = ~tck;
  assign chain_tdo = 8'b0001_0010;

  dbg_tap_sel #(.NCHAINS(NCH), .IDCODE_VAL(IDV)) dut (.*);

  always @(posedge tck) if (|chain_update) upd_seen <= chain_update;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clk(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
    last_tdo = tdo;
  endtask

  task automatic shift_bits(input int len, input logic [31:0] din, input bit pause, output logic [31:0] dout);
    dout = '0;
    for (int i = 0; i < len; i++) begin
      dout[i] = last_tdo;
      clk(i == len - 1, din[i]);
    end
    if (pause) clk(1'b0, 1'b0);
    else begin clk(1'b1, 1'b0); clk(1'b0, 1'b0); end
  endtask

  task automatic scan_dr(input int len, input logic [31:0] din, input bit pause, output logic [31:0] dout);
    clk(1, 0); clk(0, 0); clk(0, 0);
    shift_bits(len, din, pause, dout);
  endtask

  task automatic scan_ir(input logic [4:0] code, input bit pause, output logic [31:0] dout);
    clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
    shift_bits(5, {27'd0, code}, pause, dout);
  endtask

  task automatic t_reset;
    check(tdo_en == 1'b0, "R1 tdo_en in reset", tdo_en, 0);
    #20 trst_n = 1'b1;
    clk(1, 0); clk(0, 0);
    check(instr == 5'h1E, "R1 instr after reset", instr, 5'h1E);
    check(chain_sel == 5'd0, "R1 chain_sel after reset", chain_sel, 0);
    check(tdo_en == 1'b0, "R10 tdo_en idle", tdo_en, 0);
  endtask

  task automatic t_idcode;
    logic [31:0] o;
    scan_dr(32, 32'hFFFF_0000, 0, o);
    check(o == IDV, "R2 idcode shift", o, IDV);
    check(tdo_en == 1'b0, "R10 tdo_en after shift", tdo_en, 0);
  endtask

  task automatic t_bypass;
    logic [31:0] o;
    scan_ir(5'h1F, 0, o);
    check(o[4:0] == 5'b00001, "R4 ir capture", o[4:0], 5'b00001);
    scan_dr(8, 32'hA5, 0, o);
    check(o[7:0] == 8'h4A, "R3 bypass delay", o[7:0], 8'h4A);
    scan_ir(5'h04, 0, o);
    scan_dr(8, 32'h3C, 0, o);
    check(o[7:0] == 8'h78, "R3 restart bypass", o[7:0], 8'h78);
    scan_ir(5'h05, 0, o);
    check(instr == 5'h1F, "R3 illegal code", instr, 5'h1F);
    scan_dr(8, 32'hC3, 0, o);
    check(o[7:0] == 8'h86, "R3 illegal bypass", o[7:0], 8'h86);
  endtask

  task automatic t_chain0_and_1;
    logic [31:0] o;
    scan_ir(5'h00, 0, o);
    scan_dr(6, 0, 0, o);
    check(o[5:0] == 6'h00, "R7 chain0 routed", o[5:0], 0);
    scan_ir(5'h02, 0, o);
    scan_dr(5, 32'd1, 0, o);
    check(o[4:0] == 5'h10, "R5 select capture", o[4:0], 5'h10);
    check(chain_sel == 5'd1, "R6 select applied", chain_sel, 1);
    scan_ir(5'h00, 0, o);
    upd_seen = '0;
    scan_dr(6, 0, 0, o);
    check(o[5:0] == 6'h3F, "R7 chain1 routed", o[5:0], 6'h3F);
    check(upd_seen == 8'h02, "R7 chain1 update", upd_seen, 8'h02);
  endtask

  task automatic t_itrsel;
    logic [31:0] o;
    scan_ir(5'h1D, 0, o);
    check(chain_sel == 5'd4, "R8 itrsel chain", chain_sel, 4);
    upd_seen = '0;
    scan_dr(4, 0, 0, o);
    check(o[3:0] == 4'hF && upd_seen == 8'h10, "R8 itrsel routed", {o[3:0], upd_seen}, 12'hF10);
    scan_ir(5'h00, 0, o);
    check(chain_sel == 5'd1, "R8 select kept", chain_sel, 1);
  endtask

  task automatic t_pause;
    logic [31:0] o;
    scan_ir(5'h02, 0, o);
    scan_dr(5, 32'd3, 1, o);
    check(chain_sel == 5'd1, "R6 held in pause", chain_sel, 1);
    clk(1, 0); clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
    check(chain_sel == 5'd3, "R9 dr pause path update", chain_sel, 3);
    shift_bits(5, 32'd1, 0, o);
    check(o[4:0] == 5'h10, "R9 dr recapture", o[4:0], 5'h10);
    scan_ir(5'h0C, 1, o);
    clk(1, 0); clk(1, 0); clk(1, 0); clk(1, 0); clk(0, 0); clk(0, 0);
    check(instr == 5'h0C, "R9 ir pause path update", instr, 5'h0C);
    shift_bits(5, 32'h1E, 0, o);
    check(instr == 5'h1E, "R9 ir after resume", instr, 5'h1E);
  endtask

  task automatic t_tlr;
    logic [31:0] o;
    scan_ir(5'h00, 0, o);
    clk(1, 0); clk(0, 0); clk(0, 0);
    check(tdo_en == 1'b1, "R10 tdo_en in shift", tdo_en, 1);
    for (int i = 0; i < 5; i++) clk(1, 0);
    clk(0, 0);
    check(instr == 5'h1E && chain_sel == 5'd0, "R11 tms reset", {instr, chain_sel}, {5'h1E, 5'd0});
  endtask

  initial begin
    fork
      begin
        t_reset(); t_idcode(); t_bypass(); t_chain0_and_1();
        t_itrsel(); t_pause(); t_tlr();
      end
      begin
        repeat (20000) @(posedge tck);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule